// File: doc/BRIEF.md
# Aligned Gain-Update Event Sequencer

This block runs one automatic gain control update at a time. The update is timed so that the digital gain correction inside the converter takes effect in the same clock cycle as the external analog amplifier's gain change. A rising edge on the threshold-crossing flag starts an update. The block then captures an analog gain code and a digital gain code from the gain-calculation logic. It issues a one-cycle write request to the amplifier, and after that a digital gain write request that it holds until the write is acknowledged.

After the acknowledge, a down-counter is loaded with a calibration delay, counted in converter output-clock cycles. When the counter expires, the block fires a single-cycle apply strobe. That strobe is the event that makes the written digital gain take effect. If automatic clearing was enabled when the update was captured, the block sends a one-cycle clear pulse back to the threshold flag in the cycle after the apply strobe. If automatic clearing was disabled, the flag stays set until other logic clears it.

Top module: `gain_align_seq`

## Requirements
- R1: An update starts only on a rising edge of `thresh_in` while `busy` is low. A level that stays high produces no new update, and no write request appears without a start.
- R2: Both gain codes are sampled in the capture cycle, which is the cycle after the start edge. `ana_wr_data` and `dig_wr_data` keep those values even if `ana_gain_in` or `dig_gain_in` change later.
- R3: `ana_wr_req` is high for exactly one cycle, the second cycle after the start edge. `dig_wr_req` rises in the cycle directly after it.
- R4: `dig_wr_req` stays high until the first cycle in which `dig_wr_ack` is sampled high. It is low from the following cycle.
- R5: With the delay value D read from `delay_cfg` in the acknowledge cycle, `apply_stb` is high for exactly one cycle, D+2 cycles after the acknowledge cycle. It never fires while the digital write is still outstanding.
- R6: If `auto_clr_en` was high in the start cycle, `thresh_clr` pulses for one cycle directly after `apply_stb`. If it was low, `thresh_clr` stays low.
- R7: `busy` is high from the capture cycle through the apply cycle, or through the clear cycle when auto-clear applies. It is low in the following cycle.
- R8: A rising edge of `thresh_in` while `busy` is high starts nothing and sets `overrun`. Once set, `overrun` stays high until reset.
- R9: When `rst_n` is low at a clock edge, the block returns to idle. After that edge `busy`, `ana_wr_req`, `dig_wr_req`, `apply_stb`, `thresh_clr` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter output clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thresh_in | input | 1 | Threshold-crossing flag |
| auto_clr_en | input | 1 | Clear the flag automatically after applying |
| delay_cfg | input | DLY_W (16) | Calibrated apply delay in clock cycles |
| ana_gain_in | input | ANA_W (6) | Analog gain code from the gain calculation |
| dig_gain_in | input | DIG_W (14) | Digital gain code from the gain calculation |
| ana_wr_req | output | 1 | One-cycle amplifier write request |
| ana_wr_data | output | ANA_W (6) | Captured analog gain code |
| dig_wr_req | output | 1 | Digital gain write request, held until acknowledged |
| dig_wr_data | output | DIG_W (14) | Captured digital gain code |
| dig_wr_ack | input | 1 | Acknowledge of the digital gain write |
| apply_stb | output | 1 | One-cycle digital gain apply event |
| thresh_clr | output | 1 | One-cycle clear pulse to the threshold flag |
| busy | output | 1 | Update in progress |
| overrun | output | 1 | Sticky: a start edge arrived while busy |

## Verification
Each table entry drives a full update and varies four inputs: the delay value (zero, one, small, and a larger count), how long the acknowledge is held off, the auto-clear setting, and the gain codes. Measuring the distance from the acknowledge to the apply strobe across these delays distinguishes an off-by-one in the counter from a count that starts at the wrong cycle. Changing the gain inputs right after capture shows whether the outputs were truly sampled or just pass the inputs through. Directed cases cover three further situations: a flag that stays high after a non-clearing update, a second edge arriving in the middle of an update, and a reset during the digital write.

// File: rtl/gas_pkg.sv
// Package gas_pkg
// Purpose : shared sequencer state type for the gain-update sequencer.
// Assumes : nothing beyond IEEE 1800-2017 enum support.
package gas_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CAPTURE = 3'd1,
        ST_WR_ANA  = 3'd2,
        ST_WR_DIG  = 3'd3,
        ST_WAIT    = 3'd4,
        ST_APPLY   = 3'd5,
        ST_CLEAR   = 3'd6
    } gas_state_e;
endpackage

// File: rtl/gas_rise_det.sv
// Module gas_rise_det
// Purpose : flags the cycle in which a level input goes from low to high.
// Assumes : level_in is synchronous to clk; the history bit resets low, so
//           a level already high when reset is released counts as a rise.
module gas_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_o
);
    logic lvl_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= level_in;
    end

    assign rise_o = level_in & ~lvl_q;
endmodule

// File: rtl/gas_gain_hold.sv
// Module gas_gain_hold
// Purpose : holds one gain code, loaded on request and kept otherwise.
// Assumes : load is a single-cycle enable from the sequencer.
module gas_gain_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the code on load, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/gas_delay_cnt.sv
// Module gas_delay_cnt
// Purpose : loadable down-counter that measures the apply delay.
// Assumes : load and run are never needed together; load takes priority.
//           The counter stops at zero.
module gas_delay_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load the delay, then count down one per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load)                     cnt_q <= load_val;
        else if (run && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/gain_align_seq.sv
// Module gain_align_seq
// Purpose : sequences one gain update. It starts on a threshold edge,
//           captures both gain codes, writes the analog code, then the
//           digital code (waiting for its acknowledge), waits the
//           calibrated delay, fires the apply strobe and optionally clears
//           the threshold flag.
// Assumes : delay_cfg is held stable during normal operation; auto_clr_en
//           is sampled in the start cycle; the synchronous reset is active low.
module gain_align_seq
    import gas_pkg::*;
#(
    parameter int ANA_W = 6,
    parameter int DIG_W = 14,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thresh_in,
    input  logic             auto_clr_en,
    input  logic [DLY_W-1:0] delay_cfg,
    input  logic [ANA_W-1:0] ana_gain_in,
    input  logic [DIG_W-1:0] dig_gain_in,
    output logic             ana_wr_req,
    output logic [ANA_W-1:0] ana_wr_data,
    output logic             dig_wr_req,
    output logic [DIG_W-1:0] dig_wr_data,
    input  logic             dig_wr_ack,
    output logic             apply_stb,
    output logic             thresh_clr,
    output logic             busy,
    output logic             overrun
);
    gas_state_e state_q, state_d;
    logic       start_edge;
    logic       auto_q;
    logic       ovr_q;
    logic       cnt_zero;
    logic       cnt_load;
    logic       capture;

    gas_rise_det u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (thresh_in),
        .rise_o   (start_edge)
    );

    assign capture  = (state_q == ST_CAPTURE);
    assign cnt_load = (state_q == ST_WR_DIG) && dig_wr_ack;

    gas_gain_hold #(.W(ANA_W)) u_ana_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (capture),
        .d     (ana_gain_in),
        .q     (ana_wr_data)
    );

    gas_gain_hold #(.W(DIG_W)) u_dig_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (capture),
        .d     (dig_gain_in),
        .q     (dig_wr_data)
    );

    gas_delay_cnt #(.W(DLY_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (delay_cfg),
        .run      (state_q == ST_WAIT),
        .zero_o   (cnt_zero)
    );

    // Next-state decode for the update sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_edge) state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_WR_ANA;
            ST_WR_ANA:  state_d = ST_WR_DIG;
            ST_WR_DIG:  if (dig_wr_ack) state_d = ST_WAIT;
            ST_WAIT:    if (cnt_zero) state_d = ST_APPLY;
            ST_APPLY:   state_d = auto_q ? ST_CLEAR : ST_IDLE;
            ST_CLEAR:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register, auto-clear mode latch and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            auto_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_edge) auto_q <= auto_clr_en;
            if (state_q != ST_IDLE && start_edge) ovr_q  <= 1'b1;
        end
    end

    assign ana_wr_req = (state_q == ST_WR_ANA);
    assign dig_wr_req = (state_q == ST_WR_DIG);
    assign apply_stb  = (state_q == ST_APPLY);
    assign thresh_clr = (state_q == ST_CLEAR);
    assign busy       = (state_q != ST_IDLE);
    assign overrun    = ovr_q;

    // R3
    ana_then_dig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ana_wr_req |=> (dig_wr_req && !ana_wr_req));

    // R4
    dig_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_wr_req && !dig_wr_ack) |=> dig_wr_req);

    // R5
    apply_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb |=> !apply_stb);

    // R5
    apply_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb |-> (!dig_wr_req && $past(state_q) == ST_WAIT && $past(cnt_zero)));

    // R5
    wait_until_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !cnt_zero) |=> (state_q == ST_WAIT));

    // R6
    clear_after_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_clr |-> $past(apply_stb));

    // R7
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_wr_req || dig_wr_req || apply_stb || thresh_clr) |-> busy);

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

// File: tb/tb_gain_align_seq.sv
module tb_gain_align_seq;
    localparam int ANA_W = 6;
    localparam int DIG_W = 14;
    localparam int DLY_W = 16;
    localparam int NVEC  = 6;

    // Vector table: delay, auto-clear, analog code, digital code, ack hold-off.
    localparam int VD [NVEC] = '{0, 1, 5, 3, 40, 2};
    localparam int VA [NVEC] = '{1, 0, 1, 0, 1, 0};
    localparam int VG [NVEC] = '{6'h15, 6'h3F, 6'h01, 6'h2A, 6'h00, 6'h33};
    localparam int VX [NVEC] = '{14'h1234, 14'h0001, 14'h3FFF, 14'h2AAA, 14'h0F0F, 14'h1000};
    localparam int VW [NVEC] = '{0, 3, 1, 0, 2, 5};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             thresh_in;
    logic             auto_clr_en;
    logic [DLY_W-1:0] delay_cfg;
    logic [ANA_W-1:0] ana_gain_in;
    logic [DIG_W-1:0] dig_gain_in;
    logic             ana_wr_req;
    logic [ANA_W-1:0] ana_wr_data;
    logic             dig_wr_req;
    logic [DIG_W-1:0] dig_wr_data;
    logic             dig_wr_ack;
    logic             apply_stb;
    logic             thresh_clr;
    logic             busy;
    logic             overrun;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gain_align_seq #(.ANA_W(ANA_W), .DIG_W(DIG_W), .DLY_W(DLY_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .thresh_in   (thresh_in),
        .auto_clr_en (auto_clr_en),
        .delay_cfg   (delay_cfg),
        .ana_gain_in (ana_gain_in),
        .dig_gain_in (dig_gain_in),
        .ana_wr_req  (ana_wr_req),
        .ana_wr_data (ana_wr_data),
        .dig_wr_req  (dig_wr_req),
        .dig_wr_data (dig_wr_data),
        .dig_wr_ack  (dig_wr_ack),
        .apply_stb   (apply_stb),
        .thresh_clr  (thresh_clr),
        .busy        (busy),
        .overrun     (overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full update; called at a negedge, returns at a negedge with idle DUT.
    task automatic run_vec(input int d, input int au, input int ag, input int dg, input int w);
        delay_cfg   = DLY_W'(d);
        auto_clr_en = au[0];
        ana_gain_in = ANA_W'(ag);
        dig_gain_in = DIG_W'(dg);
        thresh_in   = 1'b1;
        @(negedge clk);                       // capture cycle
        chk("R7 busy at capture", busy, 1);
        chk("R3 no early analog req", ana_wr_req, 0);
        @(negedge clk);                       // analog write cycle
        chk("R3 analog req", ana_wr_req, 1);
        chk("R2 analog data", ana_wr_data, ag);
        ana_gain_in = ~ANA_W'(ag);
        dig_gain_in = ~DIG_W'(dg);
        auto_clr_en = ~au[0];
        @(negedge clk);                       // digital write cycle
        chk("R3 analog single", ana_wr_req, 0);
        chk("R3 digital follows", dig_wr_req, 1);
        chk("R2 digital data held", dig_wr_data, dg);
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            chk("R4 req held", dig_wr_req, 1);
        end
        dig_wr_ack = 1'b1;
        @(negedge clk);
        dig_wr_ack = 1'b0;
        chk("R4 req dropped", dig_wr_req, 0);
        for (int i = 0; i < d + 1; i++) begin
            chk("R5 no early apply", apply_stb, 0);
            @(negedge clk);
        end
        chk("R5 apply timing", apply_stb, 1);
        chk("R7 busy at apply", busy, 1);
        @(negedge clk);
        chk("R5 apply single", apply_stb, 0);
        if (au != 0) begin
            chk("R6 clear pulse", thresh_clr, 1);
            chk("R7 busy at clear", busy, 1);
            thresh_in = 1'b0;
            @(negedge clk);
            chk("R6 clear single", thresh_clr, 0);
            chk("R7 busy done", busy, 0);
        end else begin
            chk("R6 no clear", thresh_clr, 0);
            chk("R7 busy done", busy, 0);
            repeat (3) @(negedge clk);
            chk("R1 level no retrigger", busy, 0);
            chk("R1 no analog req", ana_wr_req, 0);
            thresh_in = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; thresh_in = 1'b0; auto_clr_en = 1'b0; delay_cfg = '0;
        ana_gain_in = '0; dig_gain_in = '0; dig_wr_ack = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 busy", busy, 0);
        chk("R9 apply", apply_stb, 0);
        chk("R9 overrun", overrun, 0);
        chk("R9 data", ana_wr_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: ack and idle inputs alone start nothing
        dig_wr_ack = 1'b1;
        repeat (2) @(negedge clk);
        dig_wr_ack = 1'b0;
        chk("R1 idle no start", busy, 0);
        chk("R1 idle no req", dig_wr_req, 0);

        for (int v = 0; v < NVEC; v++) run_vec(VD[v], VA[v], VG[v], VX[v], VW[v]);
        chk("R8 no overrun yet", overrun, 0);

        // R8: second edge during the digital write wait
        delay_cfg = 16'd2; auto_clr_en = 1'b0; thresh_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 in digital write", dig_wr_req, 1);
        thresh_in = 1'b0;
        @(negedge clk);
        thresh_in = 1'b1;
        @(negedge clk);
        chk("R8 overrun set", overrun, 1);
        chk("R8 sequence undisturbed", dig_wr_req, 1);
        dig_wr_ack = 1'b1;
        @(negedge clk);
        dig_wr_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 apply still on time", apply_stb, 1);
        @(negedge clk);
        chk("R8 back idle", busy, 0);
        repeat (2) @(negedge clk);
        chk("R8 overrun sticky", overrun, 1);
        thresh_in = 1'b0;

        // R9: reset in the middle of an update
        @(negedge clk);
        thresh_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 pre-reset req", dig_wr_req, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid reset busy", busy, 0);
        chk("R9 mid reset req", dig_wr_req, 0);
        chk("R9 mid reset overrun", overrun, 0);
        chk("R9 mid reset apply", apply_stb, 0);
        thresh_in = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule